// File: doc/BRIEF.md
# Supervisor Control and Status Register Bank

This block is the sixteen-byte control and status window of a CPU supervisor. A host reads and writes it through a plain register port with a write strobe, an address and a data byte. Reads are combinational. The bank has the following contents:

- pullup enables for four I/O pins;
- pulldown controls for the same four pins;
- a live view of the pin levels;
- a configuration and status register;
- a delay select for the reset output;
- two shadowed bytes that keep a persistent copy;
- six scratch bytes.

The block also drives the active-low reset output. That output goes low while either supply flag is raised, or when software requests a reset. After every cause has gone away, the output stays low for a programmable number of clock cycles. The software request bit clears itself once reset is under way. A mode bit sets how writes reach the two shadowed bytes:

- In persistent mode, a write updates both the working copy and the persistent copy.
- In volatile mode, a write updates only the working copy.

A power-on event reloads the working copies from the persistent ones.

Top module: `sup_ctrl_bank`

## Requirements
- R1: Index 0x0 (address 0xF0) holds four pullup enables in bits 3:0, and those bits drive `pullup_en_o`. Bits 7:4 read 0. All four enables reset to 0.
- R2: Index 0x1 keeps only bits 1:0, the hold code, and bits 7:2 read 0. Codes 0, 1, 2 and 3 select hold lengths `DLY0`, `DLY1`, `DLY2` and `DLY3` respectively.
- R3: Indices 0x4 to 0x7 each keep bit 0 for pins 0 to 3, and all other bits read 0. When bit 0 is 0, `pulldown_on_o` for that pin is 1. Each of these bits resets to 1, which leaves the pulldown off.
- R4: Index 0x8 reads `{4'b0, io_level_i}`. Writes to this index change nothing.
- R5: Index 0x9 bit assignments:
  - bit 0 reads `por_i`;
  - bit 1 reads `trip_i`;
  - bit 2 reads 1 while `rst_out_n` is low;
  - bit 3 is the volatile-mode bit;
  - bit 4 is the software reset request;
  - bits 7:5 read 0.
  Every register of the bank resets to 0 unless a requirement states another value.
- R6: While index 0x9 bit 3 is 0, a write to index 0x2 or 0x3 updates both the working copy and the persistent copy. While it is 1, the write updates only the working copy. Reads always return the working copy.
- R7: Each clock edge with `por_i` high loads the working copies from the persistent copies. The persistent copies reset to 0.
- R8: `rst_out_n` is low in every cycle in which `por_i` or `trip_i` is high. After both flags are low, `rst_out_n` goes high after exactly N rising edges, where N is the hold length of the current code.
- R9: Writing 1 to index 0x9 bit 4 pulls `rst_out_n` low straight after that edge, and bit 4 reads 1. At the next edge, bit 4 returns to 0. Reset then stays low for N+1 edges, counted from that edge.
- R10: Indices 0xA to 0xF are six independent read/write bytes.
- R11: An address whose upper nibble differs from that of `BASE` reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| por_i | input | 1 | Supply below power-on level |
| trip_i | input | 1 | Supply below trip level |
| io_level_i | input | 4 | Live I/O pin levels |
| pullup_en_o | output | 4 | Pullup enables |
| pulldown_on_o | output | 4 | Pulldown transistor enables |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The bench builds the block with hold lengths 3, 5, 7 and 9 cycles. With these values, each of the four hold codes can be timed in full, edge by edge, for power-on, trip and software causes within a few dozen cycles. Because the four lengths are distinct, reading the wrong code or making an off-by-one count shows up directly as a wrong edge count. Short holds also let several power-on pulses be used to show which shadowed values survived in the persistent copies.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam logic [3:0] IDX_PULLUP = 4'h0;
  localparam logic [3:0] IDX_HOLD   = 4'h1;
  localparam logic [3:0] IDX_SHD0   = 4'h2;
  localparam logic [3:0] IDX_PD0    = 4'h4;
  localparam logic [3:0] IDX_LEVEL  = 4'h8;
  localparam logic [3:0] IDX_CFG    = 4'h9;
  localparam logic [3:0] IDX_SCR0   = 4'hA;

  localparam int unsigned NUM_IO  = 4;
  localparam int unsigned NUM_SHD = 2;
  localparam int unsigned NUM_SCR = 6;

  localparam int unsigned CFG_VOL   = 3;
  localparam int unsigned CFG_SWRST = 4;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned DLY0  = 16,
  parameter int unsigned DLY1  = 64,
  parameter int unsigned DLY2  = 256,
  parameter int unsigned DLY3  = 1024,
  parameter int unsigned CNT_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       trip_i,
  input  logic       swrst_i,
  input  logic [1:0] code_i,
  output logic       rst_act_o
);
  logic             cause;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] hold_len(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(DLY0);
      2'd1:    return CNT_W'(DLY1);
      2'd2:    return CNT_W'(DLY2);
      default: return CNT_W'(DLY3);
    endcase
  endfunction

  assign cause = por_i | trip_i | swrst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cause)          cnt_q <= hold_len(code_i);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rst_act_o = cause | (cnt_q != '0);

  AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R8
endmodule

// File: rtl/sup_shadow.sv
module sup_shadow #(
  parameter int unsigned NSHD = 2,
  parameter int unsigned DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     por_i,
  input  logic                     vol_mode_i,
  input  logic [NSHD-1:0]          wr_sel_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NSHD-1:0][DW-1:0]  work_o
);
  logic [NSHD-1:0][DW-1:0] work_q;
  logic [NSHD-1:0][DW-1:0] pers_q;

  for (genvar g = 0; g < NSHD; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pers_q[g] <= '0;
      else if (wr_sel_i[g] && !vol_mode_i) pers_q[g] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           work_q[g] <= '0;
      else if (por_i)       work_q[g] <= pers_q[g];
      else if (wr_sel_i[g]) work_q[g] <= wdata_i;
    end
  end

  assign work_o = work_q;

  AST_PERSIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    vol_mode_i |=> $stable(pers_q)); // R6
  AST_POR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (work_q == $past(pers_q))); // R7
endmodule

// File: rtl/sup_ctrl_bank.sv
module sup_ctrl_bank
  import sup_pkg::*;
#(
  parameter logic [7:0]  BASE = 8'hF0,
  parameter int unsigned DLY0 = 16,
  parameter int unsigned DLY1 = 64,
  parameter int unsigned DLY2 = 256,
  parameter int unsigned DLY3 = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       por_i,
  input  logic       trip_i,
  input  logic [3:0] io_level_i,
  output logic [3:0] pullup_en_o,
  output logic [3:0] pulldown_on_o,
  output logic       rst_out_n
);
  localparam int unsigned MAXD  = max2(max2(DLY0, DLY1), max2(DLY2, DLY3));
  localparam int unsigned CNT_W = $clog2(MAXD + 1);

  logic        hit;
  logic [3:0]  idx;
  logic [15:0] wsel;

  logic [NUM_IO-1:0]        pullup_q;
  logic [1:0]               hold_q;
  logic                     vol_q;
  logic                     swrst_q;
  logic [NUM_IO-1:0]        pd_q;
  logic [NUM_SCR-1:0][7:0]  scr_q;
  logic [NUM_SHD-1:0][7:0]  shd_work;
  logic                     rst_act;
  logic [7:0]               cfg_view;

  assign hit  = (reg_addr_i[7:4] == BASE[7:4]);
  assign idx  = reg_addr_i[3:0];
  assign wsel = (reg_wr_i && hit) ? (16'd1 << idx) : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pullup_q <= '0;
      hold_q   <= '0;
      vol_q    <= 1'b0;
    end else begin
      if (wsel[IDX_PULLUP]) pullup_q <= reg_wdata_i[NUM_IO-1:0];
      if (wsel[IDX_HOLD])   hold_q   <= reg_wdata_i[1:0];
      if (wsel[IDX_CFG])    vol_q    <= reg_wdata_i[CFG_VOL];
    end
  end

  // Self-clear takes priority: the request lives for exactly one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  swrst_q <= 1'b0;
    else if (swrst_q && rst_act)                 swrst_q <= 1'b0;
    else if (wsel[IDX_CFG] && reg_wdata_i[CFG_SWRST]) swrst_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_IO; g++) begin : g_pd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pd_q[g] <= 1'b1;
      else if (wsel[IDX_PD0 + g])  pd_q[g] <= reg_wdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  scr_q[g] <= '0;
      else if (wsel[IDX_SCR0 + g]) scr_q[g] <= reg_wdata_i;
    end
  end

  sup_shadow #(.NSHD(NUM_SHD), .DW(8)) shadow_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_i      (por_i),
    .vol_mode_i (vol_q),
    .wr_sel_i   (wsel[IDX_SHD0 +: NUM_SHD]),
    .wdata_i    (reg_wdata_i),
    .work_o     (shd_work)
  );

  sup_rst_timer #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3), .CNT_W(CNT_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_i     (por_i),
    .trip_i    (trip_i),
    .swrst_i   (swrst_q),
    .code_i    (hold_q),
    .rst_act_o (rst_act)
  );

  assign cfg_view = {3'b000, swrst_q, vol_q, rst_act, trip_i, por_i};

  always_comb begin
    reg_rdata_o = '0;
    if (hit) begin
      case (idx)
        IDX_PULLUP:    reg_rdata_o = {4'b0, pullup_q};
        IDX_HOLD:      reg_rdata_o = {6'b0, hold_q};
        IDX_SHD0:      reg_rdata_o = shd_work[0];
        IDX_SHD0 + 1:  reg_rdata_o = shd_work[1];
        IDX_LEVEL:     reg_rdata_o = {4'b0, io_level_i};
        IDX_CFG:       reg_rdata_o = cfg_view;
        default: begin
          if (idx >= IDX_SCR0)
            reg_rdata_o = scr_q[3'(idx - IDX_SCR0)];
          else if (idx >= IDX_PD0 && idx < IDX_PD0 + 4'(NUM_IO))
            reg_rdata_o = {7'b0, pd_q[2'(idx - IDX_PD0)]};
        end
      endcase
    end
  end

  assign pullup_en_o   = pullup_q;
  assign pulldown_on_o = ~pd_q;
  assign rst_out_n     = ~rst_act;

  AST_SWRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> !swrst_q); // R9
  AST_SUPPLY_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (por_i || trip_i) |-> !rst_out_n); // R8
  AST_LEVEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && idx == IDX_LEVEL) |-> (reg_rdata_o[7:4] == 4'b0)); // R4
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (reg_rdata_o == 8'h00)); // R11
endmodule

// File: tb/sup_ctrl_bank_tb.sv
module sup_ctrl_bank_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned D0 = 3, D1 = 5, D2 = 7, D3 = 9;
  localparam int NV = 13;
  // {addr, wdata, expected read, requirement number}
  localparam logic [31:0] VEC [NV] = '{
    {8'hF0, 8'hFF, 8'h0F, 8'd1},   // R1
    {8'hF0, 8'hA5, 8'h05, 8'd1},   // R1
    {8'hF1, 8'hFE, 8'h02, 8'd2},   // R2
    {8'hF1, 8'h01, 8'h01, 8'd2},   // R2
    {8'hF4, 8'hFE, 8'h00, 8'd3},   // R3
    {8'hF7, 8'hFF, 8'h01, 8'd3},   // R3
    {8'hF8, 8'hFF, 8'h0A, 8'd4},   // R4
    {8'hFA, 8'h5A, 8'h5A, 8'd10},  // R10
    {8'hFF, 8'hC3, 8'hC3, 8'd10},  // R10
    {8'hFC, 8'h81, 8'h81, 8'd10},  // R10
    {8'h10, 8'h77, 8'h00, 8'd11},  // R11
    {8'hEF, 8'h77, 8'h00, 8'd11},  // R11
    {8'h00, 8'hFF, 8'h00, 8'd11}   // R11
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, por = 1'b0, trip = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic [3:0] io_level = 4'b1010, pullup_en, pulldown_on;
  logic rst_out_n;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sup_ctrl_bank #(.BASE(8'hF0), .DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .por_i(por), .trip_i(trip),
    .io_level_i(io_level), .pullup_en_o(pullup_en), .pulldown_on_o(pulldown_on),
    .rst_out_n(rst_out_n)
  );

  function automatic int hold_of(input int c);
    return (c == 0) ? D0 : (c == 1) ? D1 : (c == 2) ? D2 : D3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // Counts rising edges until rst_out_n is seen high, sampled mid-cycle.
  task automatic count_hold(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_out_n) break;
    end
  endtask

  task automatic por_pulse();
    int n;
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    count_hold(n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: R1 R3 R5 R8
    chk("R8 reset idle", rst_out_n, 1);
    chk("R1 reset pullup", pullup_en, 0);
    chk("R3 reset pulldown", pulldown_on, 0);
    rd_chk("R1 reset read", 8'hF0, 8'h00);
    rd_chk("R3 reset read", 8'hF5, 8'h01);
    rd_chk("R5 reset cfg", 8'hF9, 8'h00);
    rd_chk("R7 reset shadow", 8'hF3, 8'h00);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][31:24], VEC[v][23:16]);
      rd_chk($sformatf("R%0d vector %0d", VEC[v][7:0], v), VEC[v][31:24], VEC[v][15:8]);
    end
    rd_chk("R11 F0 untouched by 00 write", 8'hF0, 8'h05);
    chk("R1 pullup pins", pullup_en, 4'b0101);
    chk("R3 pulldown pins", pulldown_on, 4'b0001);
    io_level = 4'b0101;
    rd_chk("R4 live level", 8'hF8, 8'h05);

    // R2 R8: power-on hold length for each code
    for (int c = 0; c < 4; c++) begin
      wr(8'hF1, 8'(c));
      @(negedge clk); por = 1'b1;
      @(negedge clk);
      chk("R8 low during por", rst_out_n, 0);
      if (c == 0) rd_chk("R5 cfg with por", 8'hF9, 8'h05);
      @(negedge clk); por = 1'b0;
      count_hold(n);
      chk($sformatf("R8 por hold code %0d", c), n, hold_of(c));
    end

    // R8 trip, code 3
    @(negedge clk); trip = 1'b1;
    @(negedge clk);
    rd_chk("R5 cfg with trip", 8'hF9, 8'h06);
    @(negedge clk); trip = 1'b0;
    count_hold(n);
    chk("R8 trip hold", n, D3);

    // R9 software reset, code 2
    wr(8'hF1, 8'h02);
    wr(8'hF9, 8'h10);
    chk("R9 immediate low", rst_out_n, 0);
    rd_chk("R9 request visible", 8'hF9, 8'h14);
    @(posedge clk);
    @(negedge clk);
    rd_chk("R9 self cleared", 8'hF9, 8'h04);
    n = 1;
    for (int i = 0; i < 200 && !rst_out_n; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk("R9 hold length", n, D2 + 1);

    // R6 R7 shadowed bytes
    wr(8'hF2, 8'h11);
    rd_chk("R6 persistent write", 8'hF2, 8'h11);
    wr(8'hF9, 8'h08);
    wr(8'hF2, 8'h22);
    rd_chk("R6 volatile working", 8'hF2, 8'h22);
    por_pulse();
    rd_chk("R7 reload keeps persistent", 8'hF2, 8'h11);
    wr(8'hF3, 8'h44);
    por_pulse();
    rd_chk("R6 volatile not persisted", 8'hF3, 8'h00);
    wr(8'hF9, 8'h00);
    wr(8'hF3, 8'h66);
    por_pulse();
    rd_chk("R7 reload persisted", 8'hF3, 8'h66);
    rd_chk("R10 scratch kept", 8'hFA, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule